// File: doc/BRIEF.md
# Asynchronous NOR Flash Bus Timing Engine

This block sits between a simple single-word request port and the pins of an asynchronous parallel NOR flash. It turns one read, status-poll read or write request into chip-enable, output-enable and write-enable strobes, a held address, and a write-data bus with its tristate enable. Each interval is given as a nanosecond parameter. It is turned into a whole number of system clock cycles while the design is elaborated, using the clock period parameter. For reads, the returned word is captured on the clock edge where the access window closes. A one-cycle acknowledge then reports that the access has ended.

Status polling while the flash runs an embedded program or erase uses a separate request flag. A poll read delays output-enable after the address and chip-enable are set up. Two polls in a row are kept apart by a minimum time in which both strobes are high. The engine also spaces a write and a following read, and it keeps its own data drivers off until the flash has had time to release the bus after a read. Which flash commands to issue is left to the requester.

Top module: `nor_bus_engine`

## Requirements
- R1: After reset, flash_ce_n, flash_oe_n and flash_we_n are high, dq_oe and ack are low.
- R2: A normal read drives chip-enable and output-enable low on the same edge, keeps flash_addr stable while chip-enable is low, and returns the flash word on rdata with ack.
- R3: A poll read lowers output-enable exactly ceil(T_ASO_NS/CLK_NS) cycles after chip-enable, and returns the flash word on rdata with ack.
- R4: Between two consecutive poll reads, chip-enable and output-enable stay high for at least ceil(T_PH_NS/CLK_NS) cycles.
- R5: A write lowers chip-enable and write-enable and raises dq_oe on one edge. Write-enable stays low for max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) cycles, with dq_out equal to the request data throughout. Write-enable and output-enable are never low together.
- R6: After write-enable rises, flash_addr and the driven data are held for ceil(T_AH_NS/CLK_NS) cycles. Then dq_oe falls in the same edge that raises ack.
- R7: A read or poll that follows a write starts no sooner than ceil(T_WR_NS/CLK_NS) cycles after write-enable rose.
- R8: dq_oe is never high while output-enable is low, and it rises no sooner than ceil(T_DF_NS/CLK_NS) cycles after output-enable last rose.
- R9: ack is a single-cycle pulse, one per accepted request. A request is taken only while req_ready is high.
- R10: Each interval is ceil(ns/CLK_NS) cycles with a floor of one. A read acks max(ACC,OE) cycles after chip-enable falls. A poll acks ASO + max(ACC-ASO, OE, 1) cycles after chip-enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid; taken on an edge where req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_poll | input | 1 | With req_write low: 1 = status-poll read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Engine idle and every spacing rule met for the presented request |
| ack | output | 1 | One-cycle pulse at the end of an access |
| rdata | output | DW | Captured read word, valid with ack |
| flash_addr | output | AW | Address pins |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| dq_out | output | DW | Data driven to the flash |
| dq_oe | output | 1 | Host data driver enable |
| dq_in | input | DW | Data from the flash |

## Verification
Two things can happen in the same cycle. A spacing timer can expire (bus turnaround after a read, the poll gap, or write-to-read recovery) on the very edge where a pending request is taken. The acknowledge of one access can also share a cycle with the request for the next one. The bench provokes this by presenting the next request as soon as the previous access acknowledges, so every new access starts on the earliest legal edge. A monitor measures the pin distances in cycles against the minimums computed from the nanosecond values. The flash model returns a wrong word to any read sampled before its access window has fully elapsed.

// File: rtl/nor_timing_pkg.sv
package nor_timing_pkg;

  // Whole clock cycles covering an interval, never fewer than one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ASO   = 3'd1,
    ST_RACT  = 3'd2,
    ST_WLOW  = 3'd3,
    ST_WHOLD = 3'd4
  } nor_state_e;

endpackage

// File: rtl/nor_span_timer.sv
// Loadable down-counter. "expired" is high in the last cycle of a span
// loaded with N, so an action taken on the next edge lands N cycles after
// the loading edge.
module nor_span_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt <= CW'(1));
endmodule

// File: rtl/nor_rd_capture.sv
module nor_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (cap) dout <= din;
  end
endmodule

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
  import nor_timing_pkg::*;
#(
  parameter int AW        = 22,
  parameter int DW        = 16,
  parameter int CLK_NS    = 20,
  parameter int T_ACC_NS  = 90,
  parameter int T_OE_NS   = 35,
  parameter int T_ASO_NS  = 15,
  parameter int T_PH_NS   = 20,
  parameter int T_DS_NS   = 40,
  parameter int T_WP_NS   = 35,
  parameter int T_AH_NS   = 45,
  parameter int T_WR_NS   = 20,
  parameter int T_DF_NS   = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_write,
  input  logic          req_poll,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] flash_addr,
  output logic          flash_ce_n,
  output logic          flash_oe_n,
  output logic          flash_we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  localparam int ACC_C  = ns2cyc(T_ACC_NS, CLK_NS);
  localparam int OE_C   = ns2cyc(T_OE_NS,  CLK_NS);
  localparam int ASO_C  = ns2cyc(T_ASO_NS, CLK_NS);
  localparam int PH_C   = ns2cyc(T_PH_NS,  CLK_NS);
  localparam int DS_C   = ns2cyc(T_DS_NS,  CLK_NS);
  localparam int WP_C   = ns2cyc(T_WP_NS,  CLK_NS);
  localparam int AH_C   = ns2cyc(T_AH_NS,  CLK_NS);
  localparam int WTR_C  = ns2cyc(T_WR_NS,  CLK_NS);
  localparam int DF_C   = ns2cyc(T_DF_NS,  CLK_NS);
  localparam int RD_C   = imax(ACC_C, OE_C);
  localparam int PACT_C = imax(imax(ACC_C - ASO_C, OE_C), 1);
  localparam int WL_C   = imax(WP_C, DS_C);
  localparam int MAXC   = imax(imax(imax(RD_C, PACT_C), imax(WL_C, AH_C)),
                               imax(imax(PH_C, WTR_C), imax(DF_C, ASO_C)));
  localparam int CW     = $clog2(MAXC + 1) + 1;

  // Timer slots
  localparam int T_PHASE = 0;  // length of the current pin phase
  localparam int T_TA    = 1;  // bus release after a read
  localparam int T_PGAP  = 2;  // high gap between polls
  localparam int T_WTR   = 3;  // write-to-read recovery
  localparam int NT      = 4;

  nor_state_e    state;
  logic          cur_poll;
  logic          accept;
  logic          capture;
  logic [NT-1:0] t_load;
  logic [NT-1:0] t_exp;
  logic [CW-1:0] t_val [NT];

  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_tmr
      nor_span_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load[gi]),
        .val     (t_val[gi]),
        .expired (t_exp[gi])
      );
    end
  endgenerate

  // Admission: idle, and every spacing rule for this kind of request met
  always_comb begin
    req_ready = 1'b0;
    if (state == ST_IDLE) begin
      if (req_write) req_ready = t_exp[T_TA];
      else           req_ready = t_exp[T_WTR] && (!req_poll || t_exp[T_PGAP]);
    end
  end

  assign accept  = req && req_ready;
  assign capture = (state == ST_RACT) && t_exp[T_PHASE];

  always_comb begin
    t_load[T_PHASE] = accept
                   || ((state == ST_ASO)  && t_exp[T_PHASE])
                   || ((state == ST_WLOW) && t_exp[T_PHASE]);
    if (accept) begin
      if (req_write)     t_val[T_PHASE] = CW'(WL_C);
      else if (req_poll) t_val[T_PHASE] = CW'(ASO_C);
      else               t_val[T_PHASE] = CW'(RD_C);
    end else if (state == ST_ASO) begin
      t_val[T_PHASE] = CW'(PACT_C);
    end else begin
      t_val[T_PHASE] = CW'(AH_C);
    end
    t_load[T_TA]   = capture;
    t_val[T_TA]    = CW'(DF_C);
    t_load[T_PGAP] = capture && cur_poll;
    t_val[T_PGAP]  = CW'(PH_C);
    t_load[T_WTR]  = (state == ST_WLOW) && t_exp[T_PHASE];
    t_val[T_WTR]   = CW'(WTR_C);
  end

  nor_rd_capture #(.DW(DW)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .cap  (capture),
    .din  (dq_in),
    .dout (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_poll   <= 1'b0;
      flash_addr <= '0;
      flash_ce_n <= 1'b1;
      flash_oe_n <= 1'b1;
      flash_we_n <= 1'b1;
      dq_out     <= '0;
      dq_oe      <= 1'b0;
      ack        <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          flash_addr <= req_addr;
          flash_ce_n <= 1'b0;
          cur_poll   <= req_poll && !req_write;
          if (req_write) begin
            flash_we_n <= 1'b0;
            dq_out     <= req_wdata;
            dq_oe      <= 1'b1;
            state      <= ST_WLOW;
          end else if (req_poll) begin
            state      <= ST_ASO;
          end else begin
            flash_oe_n <= 1'b0;
            state      <= ST_RACT;
          end
        end
        ST_ASO: if (t_exp[T_PHASE]) begin
          flash_oe_n <= 1'b0;
          state      <= ST_RACT;
        end
        ST_RACT: if (t_exp[T_PHASE]) begin
          flash_ce_n <= 1'b1;
          flash_oe_n <= 1'b1;
          ack        <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_WLOW: if (t_exp[T_PHASE]) begin
          flash_we_n <= 1'b1;
          flash_ce_n <= 1'b1;
          state      <= ST_WHOLD;
        end
        ST_WHOLD: if (t_exp[T_PHASE]) begin
          dq_oe <= 1'b0;
          ack   <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Pin-history counters used only by the assertions below
  logic [7:0] oe_hi_age;
  logic [7:0] we_lo_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_age <= 8'hFF;
      we_lo_age <= 8'd0;
    end else begin
      if (!flash_oe_n)            oe_hi_age <= 8'd0;
      else if (oe_hi_age != 8'hFF) oe_hi_age <= oe_hi_age + 8'd1;
      if (flash_we_n)             we_lo_age <= 8'd0;
      else if (we_lo_age != 8'hFF) we_lo_age <= we_lo_age + 8'd1;
    end
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!flash_oe_n && !flash_we_n)); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_we_n) |-> (we_lo_age >= 8'(WP_C))); // R5
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> flash_oe_n); // R8
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (oe_hi_age >= 8'(DF_C))); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!flash_ce_n && !$fell(flash_ce_n)) |-> $stable(flash_addr)); // R2

endmodule

// File: tb/nor_bus_engine_tb.sv
module nor_bus_engine_tb;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int CK = 20;
  localparam int NS_DF  = 50;
  localparam int NS_PH  = 60;
  localparam int NS_WR  = 100;

  function automatic int cy(input int ns);
    int c;
    c = (ns + CK - 1) / CK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC_C  = cy(90);
  localparam int OE_C   = cy(35);
  localparam int ASO_C  = cy(15);
  localparam int PH_C   = cy(NS_PH);
  localparam int WL_C   = mx(cy(35), cy(40));
  localparam int AH_C   = cy(45);
  localparam int WTR_C  = cy(NS_WR);
  localparam int DF_C   = cy(NS_DF);
  localparam int RD_C   = mx(ACC_C, OE_C);
  localparam int PACT_C = mx(mx(ACC_C - ASO_C, OE_C), 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_write = 1'b0;
  logic          req_poll = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] flash_addr;
  logic          flash_ce_n, flash_oe_n, flash_we_n;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [DW-1:0] dq_in;

  always #(CK/2) clk = ~clk;

  nor_bus_engine #(
    .AW(AW), .DW(DW), .CLK_NS(CK),
    .T_DF_NS(NS_DF), .T_PH_NS(NS_PH), .T_WR_NS(NS_WR)
  ) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_poll(req_poll),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ack(ack), .rdata(rdata), .flash_addr(flash_addr), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // Flash model: the word is valid only once both access windows have elapsed
  function automatic logic [DW-1:0] mdl(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hC3A5 ^ {a[21:16], 10'h0};
  endfunction

  int ce_age = 0;
  int oe_age = 0;
  always @(posedge clk) begin
    ce_age <= flash_ce_n ? 0 : ce_age + 1;
    oe_age <= flash_oe_n ? 0 : oe_age + 1;
  end
  assign dq_in = (!flash_ce_n && !flash_oe_n && (ce_age + 1 >= ACC_C) &&
                  (oe_age + 1 >= OE_C)) ? mdl(flash_addr) : 16'hDEAD;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit            wr;
    bit            poll;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } op_t;
  op_t sb[$];

  // Driver: pushes the expected item, then requests at the earliest legal edge
  task automatic do_op(input bit wr, input bit poll, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    op_t o;
    o.wr = wr; o.poll = poll; o.a = a; o.d = d;
    @(negedge clk);
    req_write = wr; req_poll = poll; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(o);
    req = 1'b1;
    @(posedge clk);
    #1;
    req = 1'b0;
  endtask

  // Monitor
  bit prev_ce = 1, prev_oe = 1, prev_we = 1, prev_dqoe = 0, prev_ack = 0;
  int t_ce_fall = 0, t_ce_rise = 0, t_oe_rise = -100, t_we_fall = 0, t_we_rise = -100;
  int last_kind = 0; // 0 none, 1 read, 2 poll, 3 write
  bit drv_ok = 1;
  op_t cur;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ce && !flash_ce_n) begin
        if (sb.size() > 0) cur = sb[0];
        if (cur.poll && !cur.wr && last_kind == 2)
          chk(cyc - t_ce_rise >= PH_C, "R4 poll gap", cyc - t_ce_rise, PH_C);
        if (!cur.wr && last_kind == 3)
          chk(cyc - t_we_rise >= WTR_C, "R7 write-to-read", cyc - t_we_rise, WTR_C);
        if (!cur.wr && !cur.poll)
          chk(!flash_oe_n, "R2 OE with CE", flash_oe_n, 0);
        if (cur.wr) begin
          chk(!flash_we_n && dq_oe, "R5 WE/drive with CE", {flash_we_n, dq_oe}, 1);
          drv_ok = 1;
        end
        t_ce_fall = cyc;
      end
      if (prev_oe && !flash_oe_n && cur.poll)
        chk(cyc - t_ce_fall == ASO_C, "R3 addr-to-OE setup", cyc - t_ce_fall, ASO_C);
      if (!flash_we_n && (!dq_oe || dq_out != cur.d)) drv_ok = 0;
      if (!prev_we && flash_we_n) begin
        chk(cyc - t_we_fall == WL_C, "R5 R10 WE low width", cyc - t_we_fall, WL_C);
        chk(drv_ok, "R5 data driven while WE low", drv_ok, 1);
        chk(flash_addr == cur.a && dq_out == cur.d, "R5 write addr/data",
            {flash_addr, dq_out}, {cur.a, cur.d});
        t_we_rise = cyc;
      end
      if (prev_we && !flash_we_n) t_we_fall = cyc;
      if (!prev_dqoe && dq_oe) begin
        chk(flash_oe_n, "R8 no drive during OE", flash_oe_n, 1);
        if (last_kind == 1 || last_kind == 2)
          chk(cyc - t_oe_rise >= DF_C, "R8 bus turnaround", cyc - t_oe_rise, DF_C);
      end
      if (prev_dqoe && !dq_oe) begin
        chk(cyc - t_we_rise == AH_C, "R6 hold after WE", cyc - t_we_rise, AH_C);
        chk(flash_addr == cur.a && dq_out == cur.d, "R6 addr/data held",
            {flash_addr, dq_out}, {cur.a, cur.d});
      end
      if (!prev_oe && flash_oe_n) t_oe_rise = cyc;
      if (!prev_ce && flash_ce_n) t_ce_rise = cyc;
      if (ack) begin
        chk(!prev_ack, "R9 ack single pulse", prev_ack, 0);
        chk(sb.size() > 0, "R9 ack matches a request", sb.size(), 1);
        if (sb.size() > 0) begin
          cur = sb.pop_front();
          if (cur.wr) begin
            chk(!dq_oe, "R6 drive released at ack", dq_oe, 0);
            last_kind = 3;
          end else begin
            chk(rdata == mdl(cur.a), cur.poll ? "R3 poll data" : "R2 read data",
                rdata, mdl(cur.a));
            chk(cyc - t_ce_fall == (cur.poll ? ASO_C + PACT_C : RD_C),
                "R10 access length", cyc - t_ce_fall, cur.poll ? ASO_C + PACT_C : RD_C);
            last_kind = cur.poll ? 2 : 1;
          end
        end
      end
      prev_ce = flash_ce_n; prev_oe = flash_oe_n; prev_we = flash_we_n;
      prev_dqoe = dq_oe; prev_ack = ack;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_ce_n && flash_oe_n && flash_we_n && !dq_oe && !ack, "R1 reset state",
        {flash_ce_n, flash_oe_n, flash_we_n, dq_oe, ack}, 5'b11100);
    @(negedge clk);
    rst = 1'b0;
    do_op(0, 0, 22'h000010, '0);
    do_op(0, 0, 22'h3FFFFF, '0);
    do_op(0, 1, 22'h000005, '0);
    do_op(0, 1, 22'h000005, '0);
    do_op(0, 1, 22'h000100, '0);
    do_op(1, 0, 22'h000020, 16'h1234);
    do_op(0, 0, 22'h000020, '0);
    do_op(1, 0, 22'h000040, 16'hBEEF);
    do_op(1, 0, 22'h000041, 16'h0F0F);
    do_op(0, 1, 22'h000555, '0);
    do_op(1, 0, 22'h2AAAAA, 16'hA5A5);
    do_op(0, 1, 22'h000555, '0);
    do_op(0, 0, 22'h155555, '0);
    do_op(0, 1, 22'h000555, '0);
    for (int i = 0; i < 12; i++)
      do_op(i % 3 == 0, i % 3 == 1, AW'(i * 22'h01357 + 3), DW'(i * 16'h1111 + 1));
    while (sb.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule